// File: doc/BRIEF.md
# Serial port register block

This block is the host-facing register front end of a serial port. A host reaches it over a simple word-wide register bus with address, write enable, write data, read enable and read data. The line side is two byte-wide valid/ready channels: one brings received bytes in and one carries transmitted bytes out. Baud timing and bit serialisation sit in a neighbouring block.

Received bytes go into a 16-entry queue. They are admitted only while the receiver enable bit is set. The host reads them through a status word, either with a non-destructive peek or with a read that also removes the head entry. A byte written to the data-out register goes to a one-byte holding register on the transmit channel.

A small interrupt unit keeps a raw interrupt word, a mask and an acknowledge register, and drives a single interrupt line from their product. The acknowledge has one quirk. While a transmit is pending, the first acknowledge cannot clear the transmit-done bit.

Top module: `serport_regblk`

## Requirements
- R1: After reset the receive control register reads 0x0001_0000, the status word reads 0x0140_0000, the raw interrupt word reads 0, `irq` is 0, `tx_valid` is 0 and `rx_ready` is 0.
- R2: Reading offset 0x24 returns the status word without changing the queue. The status word holds the oldest queued byte in bits 7:0 (0 when the queue is empty), bit 16 set when the queue is non-empty, and bits 22 and 24 always 1.
- R3: Reading offset 0x20 returns the same status word and removes the oldest entry when the queue is non-empty. On an empty queue it removes nothing.
- R4: The queue holds 16 bytes and returns them in arrival order across pointer wrap. While it holds 16 entries, `rx_ready` is 0 and an offered byte is not stored.
- R5: Bytes are accepted only while bit 3 of the receive control register (offset 0x08) is 1. While that bit is 0, `rx_ready` is 0.
- R6: Raw interrupt bit 3 is updated to "queue non-empty" only on a clock edge that carries a register write or an accepted byte. A pop read alone leaves it unchanged.
- R7: A write to offset 0x1C stores the word, places its low byte on `tx_data` with `tx_valid` = 1, and sets raw interrupt bits 0 and 1. A later write overwrites a byte that has not been taken. `tx_valid` falls after a cycle with `tx_ready` = 1.
- R8: A write to the acknowledge register (offset 0x30) clears bit 0 of the written value if a transmit is pending, and then clears the pending flag. The result is stored, reads back at 0x30, and its set bits are cleared in the raw interrupt word (0x34).
- R9: Offset 0x38 reads raw AND mask (the mask is at 0x2C). `irq` is 1 exactly when that product is non-zero.
- R10: The transmit control (0x00), DMA enable (0x04), receive control, mask and data-out registers read back the last written word. Other offsets read 0, and writes to them change nothing.
- R11: When a pop read and an accepted byte fall on the same edge, the head is removed, the new byte is appended and the count stays the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 6 | Byte address of the word access |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_ren | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_ren` |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Block accepts a byte this cycle |
| tx_valid | output | 1 | Transmit byte held |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Line side takes the transmit byte |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can fall on the same clock edge. The first is a pop read of the status word together with a byte arriving on the receive channel. The bench drives `bus_ren` at offset 0x20 and `rx_valid` in the same cycle. It then judges the result from the returned old head, a peek that must show the new byte, and one further pop that must empty the queue. The second is a register write together with queue activity. An acknowledge of bit 3 while a byte is queued must leave bit 3 set in the raw word, and a pop that empties the queue must leave bit 3 stale until the next write.

// File: rtl/serport_pkg.sv
package serport_pkg;

  localparam int unsigned ADDR_W = 6;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned BYTE_W = 8;

  // register offsets (byte addresses of word registers)
  localparam logic [ADDR_W-1:0] OFS_TXCTL  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_DMAEN  = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_RXCTL  = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_DOUT   = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_POP    = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_PEEK   = 6'h24;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 6'h2C;
  localparam logic [ADDR_W-1:0] OFS_ACK    = 6'h30;
  localparam logic [ADDR_W-1:0] OFS_RAW    = 6'h34;
  localparam logic [ADDR_W-1:0] OFS_MASKED = 6'h38;

  // status word fields
  localparam int unsigned STAT_AVAIL_BIT = 16;
  localparam int unsigned STAT_IDLE_BIT  = 22;
  localparam int unsigned STAT_RDY_BIT   = 24;

  // interrupt word fields
  localparam int unsigned IRQ_TXDONE_BIT = 0;
  localparam int unsigned IRQ_TXEMPT_BIT = 1;
  localparam int unsigned IRQ_RXAV_BIT   = 3;

  // receive control
  localparam int unsigned RXCTL_EN_BIT = 3;
  localparam logic [WORD_W-1:0] RXCTL_RST = 32'h0001_0000;

endpackage

// File: rtl/serport_rxq.sv
module serport_rxq #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [BYTE_W-1:0] push_byte_i,
  input  logic              pop_i,
  output logic [BYTE_W-1:0] head_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              nonempty_nxt_o
);

  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_FULL);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;

  // next state
  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push_ok) wr_d = ptr_inc(wr_q);
    if (pop_ok)  rd_d = ptr_inc(rd_q);
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // storage, written only on an accepted byte
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= push_byte_i;
  end

  assign head_o         = empty_o ? '0 : mem[rd_q];
  assign cnt_o          = cnt_q;
  assign nonempty_nxt_o = (cnt_d != '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL); // R4
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !full_o && !pop_i) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R4
  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !empty_o && !push_i) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3
  AST_BOTH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && push_i && !empty_o && !full_o) |=> $stable(cnt_q)); // R11

endmodule

// File: rtl/serport_irq.sv
module serport_irq
  import serport_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_dout_i,
  input  logic         wr_ack_i,
  input  logic         refresh_i,
  input  logic [W-1:0] ack_val_i,
  input  logic         rx_nonempty_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] masked_o,
  output logic [W-1:0] ack_o,
  output logic         irq_o
);

  logic [W-1:0] raw_q, raw_d;
  logic [W-1:0] ack_q, ack_d;
  logic         pend_q, pend_d;
  logic [W-1:0] ack_eff;
  logic [W-1:0] tx_set;
  logic [W-1:0] pend_guard;

  always_comb begin
    tx_set = '0;
    tx_set[IRQ_TXDONE_BIT] = 1'b1;
    tx_set[IRQ_TXEMPT_BIT] = 1'b1;
    pend_guard = '1;
    pend_guard[IRQ_TXDONE_BIT] = ~pend_q;
  end

  assign ack_eff = ack_val_i & pend_guard;

  // next state
  always_comb begin
    raw_d  = raw_q;
    ack_d  = ack_q;
    pend_d = pend_q;
    if (wr_dout_i) begin
      raw_d  = raw_d | tx_set;
      pend_d = 1'b1;
    end
    if (wr_ack_i) begin
      ack_d  = ack_eff;
      raw_d  = raw_d & ~ack_eff;
      pend_d = 1'b0;
    end
    if (refresh_i) raw_d[IRQ_RXAV_BIT] = rx_nonempty_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      ack_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      ack_q  <= ack_d;
      pend_q <= pend_d;
    end
  end

  assign raw_o    = raw_q;
  assign masked_o = raw_q & mask_i;
  assign ack_o    = ack_q;
  assign irq_o    = |masked_o;

  AST_DOUT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dout_i |=> (raw_o[IRQ_TXEMPT_BIT] && raw_o[IRQ_TXDONE_BIT])); // R7
  AST_ACK_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack_i && pend_q && raw_q[IRQ_TXDONE_BIT]) |=> raw_o[IRQ_TXDONE_BIT]); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack_i && !pend_q && ack_val_i[IRQ_TXEMPT_BIT]) |=> !raw_o[IRQ_TXEMPT_BIT]); // R8
  AST_RXAV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh_i |=> $stable(raw_o[IRQ_RXAV_BIT])); // R6

endmodule

// File: rtl/serport_txhold.sv
module serport_txhold #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_byte_i,
  input  logic              tx_ready_i,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o
);

  logic              vld_q, vld_d;
  logic [BYTE_W-1:0] dat_q, dat_d;

  always_comb begin
    vld_d = vld_q;
    dat_d = dat_q;
    if (load_i) begin
      vld_d = 1'b1;
      dat_d = load_byte_i;
    end else if (vld_q && tx_ready_i) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (load_i) dat_q <= dat_d;
    end
  end

  assign tx_valid_o = vld_q;
  assign tx_data_o  = dat_q;

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i && !load_i) |=> (tx_valid_o && $stable(tx_data_o))); // R7
  AST_TX_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && tx_ready_i && !load_i) |=> !tx_valid_o); // R7

endmodule

// File: rtl/serport_regblk.sv
module serport_regblk
  import serport_pkg::*;
#(
  parameter int unsigned RXQ_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              bus_ren,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready,
  output logic              irq
);

  localparam int unsigned PTR_W = (RXQ_DEPTH > 1) ? $clog2(RXQ_DEPTH) : 1;
  localparam int unsigned CNT_W = PTR_W + 1;

  // write decode
  logic we_txctl, we_dmaen, we_rxctl, we_dout, we_mask, we_ack;

  always_comb begin
    we_txctl = 1'b0;
    we_dmaen = 1'b0;
    we_rxctl = 1'b0;
    we_dout  = 1'b0;
    we_mask  = 1'b0;
    we_ack   = 1'b0;
    if (bus_wen) begin
      case (bus_addr)
        OFS_TXCTL: we_txctl = 1'b1;
        OFS_DMAEN: we_dmaen = 1'b1;
        OFS_RXCTL: we_rxctl = 1'b1;
        OFS_DOUT:  we_dout  = 1'b1;
        OFS_MASK:  we_mask  = 1'b1;
        OFS_ACK:   we_ack   = 1'b1;
        default:   ;
      endcase
    end
  end

  // plain storage registers
  logic [WORD_W-1:0] txctl_q, dmaen_q, rxctl_q, dout_q, mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txctl_q <= '0;
      dmaen_q <= '0;
      rxctl_q <= RXCTL_RST;
      dout_q  <= '0;
      mask_q  <= '0;
    end else begin
      if (we_txctl) txctl_q <= bus_wdata;
      if (we_dmaen) dmaen_q <= bus_wdata;
      if (we_rxctl) rxctl_q <= bus_wdata;
      if (we_dout)  dout_q  <= bus_wdata;
      if (we_mask)  mask_q  <= bus_wdata;
    end
  end

  // receive queue
  logic              rxq_full, rxq_empty, rxq_ne_nxt;
  logic [BYTE_W-1:0] rxq_head;
  logic [CNT_W-1:0]  rxq_cnt;
  logic              rx_accept, rx_pop;

  assign rx_ready  = rxctl_q[RXCTL_EN_BIT] && !rxq_full;
  assign rx_accept = rx_valid && rx_ready;
  assign rx_pop    = bus_ren && (bus_addr == OFS_POP) && !rxq_empty;

  serport_rxq #(
    .DEPTH  (RXQ_DEPTH),
    .BYTE_W (BYTE_W)
  ) u_rxq (
    .clk            (clk),
    .rst_n          (rst_n),
    .push_i         (rx_accept),
    .push_byte_i    (rx_data),
    .pop_i          (rx_pop),
    .head_o         (rxq_head),
    .cnt_o          (rxq_cnt),
    .full_o         (rxq_full),
    .empty_o        (rxq_empty),
    .nonempty_nxt_o (rxq_ne_nxt)
  );

  // interrupts
  logic [WORD_W-1:0] raw_w, masked_w, ack_w;

  serport_irq #(
    .W (WORD_W)
  ) u_irq (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_dout_i     (we_dout),
    .wr_ack_i      (we_ack),
    .refresh_i     (bus_wen || rx_accept),
    .ack_val_i     (bus_wdata),
    .rx_nonempty_i (rxq_ne_nxt),
    .mask_i        (mask_q),
    .raw_o         (raw_w),
    .masked_o      (masked_w),
    .ack_o         (ack_w),
    .irq_o         (irq)
  );

  // transmit holding register
  serport_txhold #(
    .BYTE_W (BYTE_W)
  ) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (we_dout),
    .load_byte_i (bus_wdata[BYTE_W-1:0]),
    .tx_ready_i  (tx_ready),
    .tx_valid_o  (tx_valid),
    .tx_data_o   (tx_data)
  );

  // read path
  logic [WORD_W-1:0] stat_w;

  always_comb begin
    stat_w = '0;
    stat_w[BYTE_W-1:0]     = rxq_head;
    stat_w[STAT_AVAIL_BIT] = !rxq_empty;
    stat_w[STAT_IDLE_BIT]  = 1'b1;
    stat_w[STAT_RDY_BIT]   = 1'b1;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_ren) begin
      case (bus_addr)
        OFS_TXCTL:  bus_rdata = txctl_q;
        OFS_DMAEN:  bus_rdata = dmaen_q;
        OFS_RXCTL:  bus_rdata = rxctl_q;
        OFS_DOUT:   bus_rdata = dout_q;
        OFS_POP:    bus_rdata = stat_w;
        OFS_PEEK:   bus_rdata = stat_w;
        OFS_MASK:   bus_rdata = mask_q;
        OFS_ACK:    bus_rdata = ack_w;
        OFS_RAW:    bus_rdata = raw_w;
        OFS_MASKED: bus_rdata = masked_w;
        default:    bus_rdata = '0;
      endcase
    end
  end

  AST_RX_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!rxctl_q[RXCTL_EN_BIT] && !rx_pop) |=> $stable(rxq_cnt)); // R5
  AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ren && bus_addr == OFS_PEEK && !rx_accept) |=> $stable(rxq_cnt)); // R2
  AST_STAT_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ren && bus_addr == OFS_PEEK) |-> (bus_rdata[STAT_IDLE_BIT] && bus_rdata[STAT_RDY_BIT])); // R2

endmodule

// File: tb/serport_regblk_tb.sv
`timescale 1ns/1ps
module serport_regblk_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  bus_addr;
  logic        bus_wen;
  logic [31:0] bus_wdata;
  logic        bus_ren;
  logic [31:0] bus_rdata;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        rx_ready;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready;
  logic        irq;

  always #2.5 clk = ~clk;

  serport_regblk u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_ren(bus_ren), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .irq(irq)
  );

  localparam logic [31:0] ST_EMPTY = 32'h0140_0000;
  localparam logic [31:0] ST_AVAIL = 32'h0141_0000;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data while a read is active
  always @(negedge clk) begin
    if (bus_ren === 1'b1) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL scoreboard: actual %h expected none", bus_rdata);
      end else begin
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  // drivers: entered and left one time unit after a rising edge
  task automatic wr(logic [5:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(posedge clk); #1;
    bus_wen = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, logic [31:0] e, string tag);
    bus_addr = a; bus_ren = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1;
    bus_ren = 1'b0;
  endtask

  task automatic rx(logic [7:0] b, logic exp_rdy, string tag);
    rx_data = b; rx_valid = 1'b1;
    chk(tag, {31'b0, rx_ready}, {31'b0, exp_rdy});
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic rd_rx(logic [5:0] a, logic [31:0] e, logic [7:0] b, string tag);
    bus_addr = a; bus_ren = 1'b1; rx_data = b; rx_valid = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1;
    bus_ren = 1'b0; rx_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wen = 1'b0; bus_wdata = '0; bus_ren = 1'b0;
    rx_valid = 1'b0; rx_data = '0; tx_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    chk("R1 tx_valid", {31'b0, tx_valid}, 32'd0);
    chk("R1 irq", {31'b0, irq}, 32'd0);
    chk("R1 rx_ready", {31'b0, rx_ready}, 32'd0);
    rd(6'h08, 32'h0001_0000, "R1 rxctl");
    rd(6'h24, ST_EMPTY, "R1 status");
    rd(6'h34, 32'h0, "R1 raw");

    // R5 receiver disabled: byte ignored
    rx(8'hAA, 1'b0, "R5 ready while disabled");
    rd(6'h24, ST_EMPTY, "R5 byte dropped while disabled");

    // enable, R2 peek and R3 pop, R6 stale bit 3
    wr(6'h08, 32'h0000_0008);
    rx(8'h11, 1'b1, "R5 ready when enabled");
    rx(8'h22, 1'b1, "R5 ready when enabled");
    rd(6'h24, ST_AVAIL | 32'h11, "R2 peek");
    rd(6'h24, ST_AVAIL | 32'h11, "R2 peek again");
    rd(6'h34, 32'h8, "R6 raw bit3 after byte");
    rd(6'h20, ST_AVAIL | 32'h11, "R3 pop first");
    rd(6'h20, ST_AVAIL | 32'h22, "R3 pop second");
    rd(6'h24, ST_EMPTY, "R3 empty after pops");
    rd(6'h34, 32'h8, "R6 bit3 stale after pop");
    rd(6'h20, ST_EMPTY, "R3 pop on empty");
    wr(6'h2C, 32'h0000_0008);
    rd(6'h34, 32'h0, "R6 bit3 refreshed on write");
    chk("R9 irq low", {31'b0, irq}, 32'd0);

    // R4 fill beyond capacity, with pointer wrap
    for (int i = 0; i < 20; i++) rx(8'h40 + 8'(i), (i < 16), "R4 ready vs fill");
    chk("R9 irq on rx avail", {31'b0, irq}, 32'd1);
    rd(6'h38, 32'h8, "R9 masked");
    for (int i = 0; i < 16; i++) rd(6'h20, ST_AVAIL | 32'(8'h40 + 8'(i)), "R4 order");
    rd(6'h24, ST_EMPTY, "R4 drained");

    // R7 transmit, R8 acknowledge quirk, R9 mask
    wr(6'h2C, 32'h0000_000F);
    wr(6'h1C, 32'h1234_5678);
    chk("R7 tx_valid", {31'b0, tx_valid}, 32'd1);
    chk("R7 tx_data", {24'b0, tx_data}, 32'h78);
    rd(6'h1C, 32'h1234_5678, "R7 dout readback");
    rd(6'h34, 32'h3, "R7 raw bits");
    rd(6'h38, 32'h3, "R9 masked");
    chk("R9 irq", {31'b0, irq}, 32'd1);
    wr(6'h1C, 32'h0000_009A);
    chk("R7 overwrite", {24'b0, tx_data}, 32'h9A);
    tx_ready = 1'b1; @(posedge clk); #1; tx_ready = 1'b0;
    chk("R7 drained", {31'b0, tx_valid}, 32'd0);
    wr(6'h30, 32'h3);
    rd(6'h34, 32'h1, "R8 bit0 survives first ack");
    rd(6'h30, 32'h2, "R8 stored ack");
    chk("R8 irq still", {31'b0, irq}, 32'd1);
    wr(6'h30, 32'h1);
    rd(6'h34, 32'h0, "R8 second ack clears");
    rd(6'h30, 32'h1, "R8 stored ack 2");
    chk("R8 irq low", {31'b0, irq}, 32'd0);

    wr(6'h2C, 32'h2);
    wr(6'h1C, 32'h55);
    rd(6'h38, 32'h2, "R9 masked subset");
    chk("R9 irq masked bit", {31'b0, irq}, 32'd1);
    wr(6'h2C, 32'h0);
    chk("R9 irq masked off", {31'b0, irq}, 32'd0);
    rd(6'h34, 32'h3, "R9 raw kept");
    wr(6'h30, 32'h3);
    wr(6'h30, 32'h1);
    rd(6'h34, 32'h0, "R8 cleared");

    // R11 pop and arrival on the same edge
    rx(8'h55, 1'b1, "R11 setup");
    rd_rx(6'h20, ST_AVAIL | 32'h55, 8'h66, "R11 pop with arrival");
    rd(6'h24, ST_AVAIL | 32'h66, "R11 new head");
    rd(6'h20, ST_AVAIL | 32'h66, "R11 single entry");
    rd(6'h24, ST_EMPTY, "R11 empty");

    // R6 ack of bit3 with data queued
    rx(8'h77, 1'b1, "R6 setup");
    wr(6'h30, 32'h8);
    rd(6'h34, 32'h8, "R6 bit3 recomputed after ack");
    rd(6'h20, ST_AVAIL | 32'h77, "R6 pop");

    // R10 plain registers and undefined offsets
    wr(6'h00, 32'hDEAD_BEEF);
    wr(6'h04, 32'h0000_0001);
    wr(6'h10, 32'hFFFF_FFFF);
    wr(6'h34, 32'hFFFF_FFFF);
    rd(6'h00, 32'hDEAD_BEEF, "R10 txctl");
    rd(6'h04, 32'h1, "R10 dmaen");
    rd(6'h10, 32'h0, "R10 undefined");
    rd(6'h34, 32'h0, "R10 raw not writable");
    rd(6'h2C, 32'h0, "R10 mask");

    // R5 disable again
    wr(6'h08, 32'h0);
    rx(8'h99, 1'b0, "R5 disabled again");
    rd(6'h24, ST_EMPTY, "R5 nothing stored");

    @(posedge clk); #1;
    chk("scoreboard drained", 32'(exp_q.size()), 32'd0);
    finish_run();
  end

endmodule